// File: doc/BRIEF.md
# Digit-Serial Two's-Complement Adder/Subtractor

This block adds or subtracts two two's-complement words that arrive as streams of digits. Each digit is `DIGIT_W` bits wide, and the least significant digit comes first. On every clock it takes one digit of each operand and the carry left over from the previous digit. From these it produces one result digit, which appears on a registered output one clock later. Inside a digit the bits are resolved in parallel by a ripple chain of full adders. A single flip-flop carries the chain's carry-out forward to the next digit.

A first-digit strobe marks the start of each word. In that cycle the carry entering the chain is forced to its initial value: 0 for addition and 1 for subtraction. The operation mode is also captured in that cycle and held for the rest of the word. Subtraction is done in two's complement: the second operand's bits are inverted, and the chain starts with a carry of 1.

`DIGIT_W = 1` gives a bit-serial unit. Setting `DIGIT_W` to the full word length gives a single-cycle parallel adder with one clock of latency. Word length is not a parameter of the block. The surrounding logic decides it by how often it raises the strobe, and each result is taken modulo 2 to the power of the word length.

Top module: `digit_serial_addsub`

## Requirements
- R1: While `rstN` is low, and at the first clock after it rises, `sumDigit` is all zeros.
- R2: The result digit for the inputs present at a rising clock edge appears on `sumDigit` just after that edge. It holds its previous value until the edge.
- R3: With `subMode` low at the first digit, the reassembled output word equals (A + B) mod 2^N, where N is the word length in bits.
- R4: With `subMode` high at the first digit, the reassembled output word equals (A − B) mod 2^N.
- R5: The carry out of the top bit of one digit is added into bit 0 of the next digit of the same word.
- R6: When `firstDigit` is high, the carry left by the previous word is discarded and the chain starts from the mode's initial carry.
- R7: The mode is taken from `subMode` only in the `firstDigit` cycle. Changes on `subMode` during the remaining digits of the word have no effect on the result.
- R8: In subtract mode, the first digit's chain starts with a carry of 1 and the B digit is inverted. As a result, 0 − 0 yields all zeros.
- R9: Word bit j travels in digit number floor(j / `DIGIT_W`), counted from 0 at the strobe, at bit position j mod `DIGIT_W`. Bit 0 of a digit is its least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| firstDigit | input | 1 | High on the least significant digit of each word |
| subMode | input | 1 | 1 = subtract B from A, 0 = add; sampled with `firstDigit` |
| aDigit | input | DIGIT_W | Current digit of operand A |
| bDigit | input | DIGIT_W | Current digit of operand B |
| sumDigit | output | DIGIT_W | Registered result digit, one clock behind its inputs |

## Verification
Suppose the held carry flip-flop is wrong. The error shows up in the next digit's output one clock later, as a result that is off by one in its least significant bit. The one exception is a stale carry at a word start, which the strobe would have overwritten; that error lands on the first output digit. A wrong mode register flips the result of every digit after the first, so words with mid-word mode toggling reveal it within two clocks. Running the same words through widths 1, 2 and 4 covers carries that cross every digit boundary position of an 8-bit word.

// File: rtl/dsas_pkg.sv
package dsas_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic loadCarry;  // use carryInit instead of the held carry
    logic carryInit;  // initial carry for the word's first digit
    logic invertB;    // complement the B digit (subtraction)
  } dsasStrobe_t;

  localparam logic ADD_CARRY_INIT = 1'b0;
  localparam logic SUB_CARRY_INIT = 1'b1;

endpackage

// File: rtl/dsas_full_adder.sv
module dsas_full_adder (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic outS,
  output logic outC
);

  always_comb begin
    outS = inA ^ inB ^ inC;
    outC = (inA & inB) | (inA & inC) | (inB & inC);
  end

endmodule

// File: rtl/dsas_ctrl.sv
module dsas_ctrl
  import dsas_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        firstDigit,
  input  logic        subMode,
  output dsasStrobe_t stb
);

  logic modeHeld;

  // Mode is latched at the word start and held for the remaining digits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeHeld <= 1'b0;
    end else if (firstDigit) begin
      modeHeld <= subMode;
    end
  end

  always_comb begin
    stb.loadCarry = firstDigit;
    stb.invertB   = firstDigit ? subMode : modeHeld;
    stb.carryInit = subMode ? SUB_CARRY_INIT : ADD_CARRY_INIT;
  end

endmodule

// File: rtl/dsas_datapath.sv
module dsas_datapath
  import dsas_pkg::*;
#(
  parameter int DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dsasStrobe_t        stb,
  input  logic [DIGIT_W-1:0] aDigit,
  input  logic [DIGIT_W-1:0] bDigit,
  output logic [DIGIT_W-1:0] sumDigit
);

  localparam int CHAIN_NODES = DIGIT_W + 1;

  logic                   carryHeld;
  logic [CHAIN_NODES-1:0] chainC;
  logic [DIGIT_W-1:0]     bEff;
  logic [DIGIT_W-1:0]     sumComb;

  always_comb begin
    bEff      = stb.invertB ? ~bDigit : bDigit;
    chainC[0] = stb.loadCarry ? stb.carryInit : carryHeld;
  end

  for (genvar i = 0; i < DIGIT_W; i++) begin : g_fa
    dsas_full_adder fa_i (
      .inA  (aDigit[i]),
      .inB  (bEff[i]),
      .inC  (chainC[i]),
      .outS (sumComb[i]),
      .outC (chainC[i+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryHeld <= 1'b0;
      sumDigit  <= '0;
    end else begin
      carryHeld <= chainC[CHAIN_NODES-1];
      sumDigit  <= sumComb;
    end
  end

endmodule

// File: rtl/digit_serial_addsub.sv
module digit_serial_addsub
  import dsas_pkg::*;
#(
  parameter int DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               firstDigit,
  input  logic               subMode,
  input  logic [DIGIT_W-1:0] aDigit,
  input  logic [DIGIT_W-1:0] bDigit,
  output logic [DIGIT_W-1:0] sumDigit
);

  dsasStrobe_t ctrlStb;

  dsas_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .firstDigit (firstDigit),
    .subMode    (subMode),
    .stb        (ctrlStb)
  );

  dsas_datapath #(.DIGIT_W(DIGIT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctrlStb),
    .aDigit   (aDigit),
    .bDigit   (bDigit),
    .sumDigit (sumDigit)
  );

endmodule

// File: rtl/dsas_checker.sv
module dsas_checker #(
  parameter int DIGIT_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               firstDigit,
  input logic               subMode,
  input logic [DIGIT_W-1:0] aDigit,
  input logic [DIGIT_W-1:0] bDigit,
  input logic [DIGIT_W-1:0] sumDigit,
  input logic               invertActive
);

  // R1: output still cleared at the first edge after reset release
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rstN) |-> sumDigit == '0);

  // R2, R3: first digit of an add word appears one clock later, carry-in 0
  assert_first_add_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(firstDigit) && !$past(subMode))
      |-> sumDigit == $past(aDigit + bDigit));

  // R8: first digit of a subtract word equals A - B on that digit
  assert_first_sub_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(firstDigit) && $past(subMode))
      |-> sumDigit == $past(aDigit - bDigit));

  // R7: operand inversion stays fixed across the digits after the first
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!firstDigit && $past(rstN)) |-> invertActive == $past(invertActive));

endmodule

bind digit_serial_addsub dsas_checker #(.DIGIT_W(DIGIT_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .firstDigit   (firstDigit),
  .subMode      (subMode),
  .aDigit       (aDigit),
  .bDigit       (bDigit),
  .sumDigit     (sumDigit),
  .invertActive (ctrlStb.invertB)
);

// File: tb/digit_serial_addsub_tb_top.sv
`timescale 1ns/1ps
module digit_serial_addsub_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic firstDigit = 1'b0;
  logic subMode = 1'b0;
  logic       a1 = '0, b1 = '0;
  logic [1:0] a2 = '0, b2 = '0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       s1;
  logic [1:0] s2;
  logic [3:0] s4;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  digit_serial_addsub #(.DIGIT_W(2)) dut_i (
    .clk(clk), .rstN(rstN), .firstDigit(firstDigit), .subMode(subMode),
    .aDigit(a2), .bDigit(b2), .sumDigit(s2));
  digit_serial_addsub #(.DIGIT_W(1)) dutBit_i (
    .clk(clk), .rstN(rstN), .firstDigit(firstDigit), .subMode(subMode),
    .aDigit(a1), .bDigit(b1), .sumDigit(s1));
  digit_serial_addsub #(.DIGIT_W(4)) dutNib_i (
    .clk(clk), .rstN(rstN), .firstDigit(firstDigit), .subMode(subMode),
    .aDigit(a4), .bDigit(b4), .sumDigit(s4));

  // {subtract, A, B}
  localparam logic [16:0] VEC [16] = '{
    {1'b0, 8'h00, 8'h00}, {1'b0, 8'hFF, 8'h01}, {1'b0, 8'h7F, 8'h01},
    {1'b0, 8'h80, 8'h80}, {1'b0, 8'h55, 8'hAA}, {1'b0, 8'h0F, 8'h01},
    {1'b0, 8'h12, 8'h34}, {1'b0, 8'hFF, 8'hFF}, {1'b1, 8'h00, 8'h01},
    {1'b1, 8'h80, 8'h01}, {1'b1, 8'h34, 8'h12}, {1'b1, 8'h12, 8'h34},
    {1'b1, 8'hFF, 8'hFF}, {1'b1, 8'h00, 8'h00}, {1'b1, 8'h01, 8'hFF},
    {1'b1, 8'hA5, 8'h5A}};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Streams one 8-bit word into all three widths; flip toggles the mode
  // input on every digit after the first.
  task automatic runWord(input logic [7:0] a, input logic [7:0] b,
                         input logic sub, input logic flip,
                         output logic [7:0] r1, output logic [7:0] r2,
                         output logic [7:0] r4);
    r1 = '0; r2 = '0; r4 = '0;
    for (int cyc = 0; cyc < 8; cyc++) begin
      @(negedge clk);
      firstDigit = (cyc == 0);
      subMode    = (cyc == 0 || !flip) ? sub : ~sub;
      a1 = a[cyc];
      b1 = b[cyc];
      a2 = (cyc < 4) ? a[cyc*2 +: 2] : 2'b00;
      b2 = (cyc < 4) ? b[cyc*2 +: 2] : 2'b00;
      a4 = (cyc < 2) ? a[cyc*4 +: 4] : 4'h0;
      b4 = (cyc < 2) ? b[cyc*4 +: 4] : 4'h0;
      @(posedge clk);
      #1;
      r1[cyc] = s1;
      if (cyc < 4) r2[cyc*2 +: 2] = s2;
      if (cyc < 2) r4[cyc*4 +: 4] = s4;
    end
    @(negedge clk);
    firstDigit = 1'b0;
  endtask

  task automatic checkWord(input string req, input logic [7:0] a,
                           input logic [7:0] b, input logic sub, input logic flip);
    logic [7:0] r1, r2, r4, exp;
    exp = sub ? (a - b) : (a + b);
    runWord(a, b, sub, flip, r1, r2, r4);
    check({req, " d=1"}, r1, exp);
    check({req, " d=2"}, r2, exp);
    check({req, " d=4"}, r4, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset d=1", {7'b0, s1}, 8'h00);
    check("R1 reset d=2", {6'b0, s2}, 8'h00);
    check("R1 reset d=4", {4'b0, s4}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    // Vector table: R3 (add) and R4 (subtract)
    for (int i = 0; i < 16; i++) begin
      checkWord(VEC[i][16] ? "R4 table" : "R3 table",
                VEC[i][15:8], VEC[i][7:0], VEC[i][16], 1'b0);
    end

    // Random operands
    for (int i = 0; i < 30; i++) begin
      checkWord("R3 random", 8'($urandom), 8'($urandom), 1'b0, 1'b0);
      checkWord("R4 random", 8'($urandom), 8'($urandom), 1'b1, 1'b0);
    end

    // R5: carry crosses every digit boundary
    checkWord("R5 carry chain", 8'h0F, 8'h01, 1'b0, 1'b0);
    checkWord("R5 carry chain", 8'h7F, 8'h01, 1'b0, 1'b0);

    // R6: leftover carry from a previous word must not leak in
    checkWord("R6 setup", 8'hFF, 8'h01, 1'b0, 1'b0);
    checkWord("R6 restart add", 8'h00, 8'h00, 1'b0, 1'b0);
    checkWord("R6 setup", 8'h00, 8'h00, 1'b1, 1'b0);
    checkWord("R6 restart after sub", 8'h00, 8'h00, 1'b0, 1'b0);

    // R7: mid-word mode toggles are ignored
    checkWord("R7 add flipped", 8'h3C, 8'h19, 1'b0, 1'b1);
    checkWord("R7 sub flipped", 8'h3C, 8'h19, 1'b1, 1'b1);
    checkWord("R7 sub flipped", 8'h05, 8'hC8, 1'b1, 1'b1);

    // R8: subtract starts with carry 1
    checkWord("R8 zero minus zero", 8'h00, 8'h00, 1'b1, 1'b0);

    // R9: lowest word bit in lowest bit of first digit
    checkWord("R9 lsb placement", 8'h01, 8'h00, 1'b0, 1'b0);
    checkWord("R9 msb placement", 8'h80, 8'h00, 1'b0, 1'b0);

    // R2: output holds until the edge, then shows the new digit
    @(negedge clk);
    prev = {4'h0, s4};
    firstDigit = 1'b1; subMode = 1'b0; a4 = 4'h3; b4 = 4'h4;
    #1;
    check("R2 hold before edge", {4'h0, s4}, prev);
    @(posedge clk);
    #1;
    check("R2 one-clock latency", {4'h0, s4}, 8'h07);
    @(negedge clk);
    firstDigit = 1'b0;

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule